// File: doc/BRIEF.md
# Interleaved I/Q Word Assembler

This block sits at the head of a transmit interpolation chain. Baseband samples arrive on a 12-bit pin bus as interleaved in-phase and quadrature words. A framing strobe marks where each burst starts. The block oversamples the bus with the fast system clock and splits the stream into parallel 12-bit I/Q pairs, each marked by a one-cycle valid pulse. A component can arrive as one full word, as two 6-bit pieces or as four 3-bit pieces. Narrow pieces always travel on the upper lines of the bus.

The time each word stays on the bus is derived from the interpolation rate N, the format and whether the extra x2 half-band stage is in use. After the strobe rises, the block counts clocks from that edge and latches every word at the middle of its window. In burst mode the strobe frames the data. Once the strobe has been low for longer than a word, the block feeds zeros. In continuous mode only full words are allowed, and the strobe level tells the block whether the word on the bus is I or Q. Settings that are not allowed raise an error flag and stop all output.

Top module: `iq_word_assembler`

## Requirements
- R1: Format code 2'b10 takes one whole 12-bit word per component. In burst mode the words after the strobe rises alternate I, Q, I, Q.
- R2: Format code 2'b01 builds each component from two 6-bit pieces taken from bus bits [11:6]. The upper half comes first, I before Q. Bits [5:0] are ignored.
- R3: Format code 2'b00 builds each component from four 3-bit pieces taken from bus bits [11:9], most significant piece first, I before Q. Bits [8:0] are ignored.
- R4: In burst mode every rising edge of the strobe restarts word timing and piece counting. The word that follows the edge is the first piece of I.
- R5: The word period P is 4N clocks for full words with the extra half-band on. P halves for half words and again for quarter words, and halves once more with that half-band off. The strobe passes through two flops. The first pair appears 3 + (2S-1)P + P/2 clocks after the first clock edge that sees the strobe high, where S is the number of pieces per component.
- R6: In burst mode, a word latched after the strobe has been low for at least one full word period enters the pair as zero. An idle bus therefore yields all-zero pairs.
- R7: In continuous mode a word latched while the strobe is high becomes the held I value. A word latched while the strobe is low produces a pair made of the held I and that word. Each rising edge of the strobe resynchronises the word timing.
- R8: cfg_err is high one clock after any of these settings: the 3-bit format with the extra half-band off, continuous mode with a format other than 12-bit, format code 2'b11, or N below 2. While the flag is high no pair is produced.
- R9: During reset all outputs are zero. out_valid lasts one clock, and out_i and out_q hold their values between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_data | input | 12 | Data bus (two's complement, sign first) |
| tx_strobe | input | 1 | Framing strobe / I-Q marker, asynchronous |
| fmt_sel | input | 2 | Word format: 10 full, 01 half, 00 quarter |
| cont_mode | input | 1 | 1 = continuous timing, 0 = burst |
| hb3_on | input | 1 | Extra x2 half-band stage engaged |
| cic_rate | input | 6 | Interpolation rate N (2..63) |
| out_i | output | 12 | Assembled in-phase sample |
| out_q | output | 12 | Assembled quadrature sample |
| out_valid | output | 1 | One-cycle pulse per new pair |
| cfg_err | output | 1 | Illegal configuration flag |

## Verification
The hardest state to reach is a resynchronising edge that comes in the middle of a burst. Examples are a single low Q word in full mode, followed by a new rise, or a strobe held at one level across several words in continuous mode. At those points the piece counter and the zero-fill rule interact. The random stimulus mixes alternate single-word lows, idle gaps of varying length and stuck strobe levels into each burst. A word-level model in the bench replays the same strobe levels to predict every pair, including the partial and zero-filled pairs that surround the gaps.

// File: rtl/iqa_pkg.sv
package iqa_pkg;

   typedef enum logic [1:0] {
      FMT_QUARTER = 2'b00,
      FMT_HALF    = 2'b01,
      FMT_FULL    = 2'b10,
      FMT_RSVD    = 2'b11
   } word_fmt_e;

   // log2 of the number of bus pieces that make one component
   function automatic logic [1:0] pieces_log2(input logic [1:0] code);
      case (code)
         FMT_FULL: pieces_log2 = 2'd0;
         FMT_HALF: pieces_log2 = 2'd1;
         default:  pieces_log2 = 2'd2;
      endcase
   endfunction

endpackage

// File: rtl/iqa_front.sv
module iqa_front #(
   parameter int DATA_W = 12,
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe_in,
   input  logic [DATA_W-1:0] data_in,
   output logic              lvl,
   output logic              rise,
   output logic [DATA_W-1:0] data_out
);

   logic              sy [STAGES+1];
   logic [DATA_W-1:0] dl [STAGES];

   genvar g;
   generate
      for (g = 0; g <= STAGES; g++) begin : g_sync
         if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (!rst_n) sy[0] <= 1'b0;
               else        sy[0] <= strobe_in;
            end
         end else begin : g_tail
            always_ff @(posedge clk) begin
               if (!rst_n) sy[g] <= 1'b0;
               else        sy[g] <= sy[g-1];
            end
         end
      end

      // data delayed by the same depth as the strobe synchroniser
      for (g = 0; g < STAGES; g++) begin : g_dly
         if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (!rst_n) dl[0] <= '0;
               else        dl[0] <= data_in;
            end
         end else begin : g_tail
            always_ff @(posedge clk) begin
               if (!rst_n) dl[g] <= '0;
               else        dl[g] <= dl[g-1];
            end
         end
      end
   endgenerate

   assign lvl      = sy[STAGES-1];
   assign rise     = sy[STAGES-1] & ~sy[STAGES];
   assign data_out = dl[STAGES-1];

endmodule

// File: rtl/iqa_window_timer.sv
module iqa_window_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             rise,
   input  logic             lvl,
   input  logic [CNT_W-1:0] period,
   output logic             cap,
   output logic             long_low
);

   logic [CNT_W-1:0] ph;
   logic [CNT_W-1:0] ph_eff;
   logic             run;
   logic [CNT_W:0]   low_cnt;

   assign ph_eff   = rise ? '0 : ph;
   assign cap      = en & (run | rise) & (ph_eff == (period >> 1));
   assign long_low = (low_cnt >= {1'b0, period});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph      <= '0;
         run     <= 1'b0;
         low_cnt <= '0;
      end else begin
         if (!en) begin
            ph  <= '0;
            run <= 1'b0;
         end else begin
            run <= run | rise;
            ph  <= (ph_eff >= period - 1'b1) ? '0 : ph_eff + 1'b1;
         end
         if (lvl)                low_cnt <= '0;
         else if (low_cnt != '1) low_cnt <= low_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/iqa_pair_packer.sv
module iqa_pair_packer #(
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap,
   input  logic              rise,
   input  logic              lvl,
   input  logic              zero,
   input  logic              cont,
   input  logic [1:0]        plog,
   input  logic [DATA_W-1:0] data,
   output logic [DATA_W-1:0] out_i,
   output logic [DATA_W-1:0] out_q,
   output logic              out_valid
);

   localparam int HW = DATA_W / 2;
   localparam int QW = DATA_W / 4;

   logic [DATA_W-1:0] acc, acc_n, din, ihold;
   logic [2:0]        idx, idx_eff, mid_idx, last_idx;
   logic [3:0]        npair, ncomp;

   assign npair    = 4'd2 << plog;
   assign ncomp    = 4'd1 << plog;
   assign last_idx = 3'(npair - 4'd1);
   assign mid_idx  = 3'(ncomp - 4'd1);
   assign idx_eff  = rise ? 3'd0 : idx;
   assign din      = zero ? '0 : data;

   always_comb begin
      case (plog)
         2'd0:    acc_n = din;
         2'd1:    acc_n = {acc[HW-1:0], din[DATA_W-1 -: HW]};
         default: acc_n = {acc[DATA_W-QW-1:0], din[DATA_W-1 -: QW]};
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc       <= '0;
         ihold     <= '0;
         idx       <= '0;
         out_i     <= '0;
         out_q     <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         if (cap && cont) begin
            idx <= '0;
            if (lvl) begin
               ihold <= data;
            end else begin
               out_i     <= ihold;
               out_q     <= data;
               out_valid <= 1'b1;
            end
         end else if (cap) begin
            acc <= acc_n;
            if (idx_eff == mid_idx) ihold <= acc_n;
            if (idx_eff == last_idx) begin
               out_i     <= ihold;
               out_q     <= acc_n;
               out_valid <= 1'b1;
               idx       <= '0;
            end else begin
               idx <= idx_eff + 3'd1;
            end
         end else begin
            idx <= idx_eff;
         end
      end
   end

endmodule

// File: rtl/iq_word_assembler.sv
module iq_word_assembler
   import iqa_pkg::*;
#(
   parameter int DATA_W      = 12,
   parameter int RATE_W      = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] pin_data,
   input  logic              tx_strobe,
   input  logic [1:0]        fmt_sel,
   input  logic              cont_mode,
   input  logic              hb3_on,
   input  logic [RATE_W-1:0] cic_rate,
   output logic [DATA_W-1:0] out_i,
   output logic [DATA_W-1:0] out_q,
   output logic              out_valid,
   output logic              cfg_err
);

   localparam int CNT_W = RATE_W + 2;

   generate
      if (DATA_W % 4 != 0) begin : g_bad_width
         $error("DATA_W must split into four equal pieces");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [1:0]        plog;
   logic [2:0]        shamt;
   logic [CNT_W-1:0]  period;
   logic              cfg_bad;
   logic              s_lvl, s_rise, cap, long_low;
   logic [DATA_W-1:0] s_data;

   assign plog    = pieces_log2(fmt_sel);
   assign shamt   = {1'b0, plog} + {2'b00, ~hb3_on};
   assign period  = {cic_rate, 2'b00} >> shamt;
   assign cfg_bad = (fmt_sel == FMT_RSVD)
                  | ((fmt_sel == FMT_QUARTER) & ~hb3_on)
                  | (cont_mode & (fmt_sel != FMT_FULL))
                  | (cic_rate < RATE_W'(2));

   always_ff @(posedge clk) begin
      if (!rst_n) cfg_err <= 1'b0;
      else        cfg_err <= cfg_bad;
   end

   iqa_front #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES)) u_front (
      .clk(clk), .rst_n(rst_n), .strobe_in(tx_strobe), .data_in(pin_data),
      .lvl(s_lvl), .rise(s_rise), .data_out(s_data)
   );

   iqa_window_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .en(~cfg_bad), .rise(s_rise), .lvl(s_lvl),
      .period(period), .cap(cap), .long_low(long_low)
   );

   iqa_pair_packer #(.DATA_W(DATA_W)) u_packer (
      .clk(clk), .rst_n(rst_n), .cap(cap), .rise(s_rise), .lvl(s_lvl),
      .zero(long_low & ~cont_mode), .cont(cont_mode), .plog(plog),
      .data(s_data), .out_i(out_i), .out_q(out_q), .out_valid(out_valid)
   );

endmodule

// File: rtl/iqa_checker.sv
module iqa_checker #(
   parameter int DATA_W = 12,
   parameter int RATE_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tx_strobe,
   input logic [1:0]        fmt_sel,
   input logic              cont_mode,
   input logic              hb3_on,
   input logic [RATE_W-1:0] cic_rate,
   input logic [DATA_W-1:0] out_i,
   input logic [DATA_W-1:0] out_q,
   input logic              out_valid,
   input logic              cfg_err
);

   logic [RATE_W+1:0] pp;
   logic [19:0]       lowc, lim;

   always_comb begin
      pp = {cic_rate, 2'b00};
      if (fmt_sel == 2'b01)      pp = pp >> 1;
      else if (fmt_sel == 2'b00) pp = pp >> 2;
      if (!hb3_on)               pp = pp >> 1;
      lim = 20'(pp) * 20'd12;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || tx_strobe) lowc <= '0;
      else if (lowc != '1)     lowc <= lowc + 20'd1;
   end

   // R8
   quarter_needs_hb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt_sel == 2'b00 && !hb3_on) |=> cfg_err);

   // R8
   cont_full_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cont_mode && fmt_sel != 2'b10) |=> cfg_err);

   // R8
   err_silences_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !out_valid);

   // R9
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   // R9
   pair_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> ($stable(out_i) && $stable(out_q)));

   // R6
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cont_mode && out_valid && lowc > lim) |-> (out_i == '0 && out_q == '0));

endmodule

bind iq_word_assembler iqa_checker #(.DATA_W(DATA_W), .RATE_W(RATE_W)) u_iqa_chk (
   .clk(clk), .rst_n(rst_n), .tx_strobe(tx_strobe), .fmt_sel(fmt_sel),
   .cont_mode(cont_mode), .hb3_on(hb3_on), .cic_rate(cic_rate),
   .out_i(out_i), .out_q(out_q), .out_valid(out_valid), .cfg_err(cfg_err)
);

// File: tb/iq_word_assembler_bench.sv
`timescale 1ns/1ps
module iq_word_assembler_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] pin_data = '0;
   logic        tx_strobe = 1'b0;
   logic [1:0]  fmt_sel = 2'b10;
   logic        cont_mode = 1'b0;
   logic        hb3_on = 1'b1;
   logic [5:0]  cic_rate = 6'd2;
   logic [11:0] out_i, out_q;
   logic        out_valid, cfg_err;

   always #2.5 clk = ~clk;

   iq_word_assembler u_iq_word_assembler (
      .clk(clk), .rst_n(rst_n), .pin_data(pin_data), .tx_strobe(tx_strobe),
      .fmt_sel(fmt_sel), .cont_mode(cont_mode), .hb3_on(hb3_on),
      .cic_rate(cic_rate), .out_i(out_i), .out_q(out_q),
      .out_valid(out_valid), .cfg_err(cfg_err)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0, n_bad = 0;
   int P = 8, S = 1, SW = 12;

   // captured output pairs
   logic [11:0] got_i [512];
   logic [11:0] got_q [512];
   int          got_c [512];
   int          got_n = 0;
   int          dbl = 0;
   logic        prev_v = 1'b0;

   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (got_n < 512) begin
            got_i[got_n] = out_i;
            got_q[got_n] = out_q;
            got_c[got_n] = cyc;
            got_n = got_n + 1;
         end
         if (prev_v) dbl = dbl + 1;
      end
      prev_v = rst_n && out_valid;
   end

   // driven word log
   logic        m_lvl [512];
   logic [11:0] m_pin [512];
   int          nw = 0;
   logic [11:0] exp_i [256];
   logic [11:0] exp_q [256];
   int          exp_n = 0;

   task automatic chk(input string tag, input int act, input int expv);
      n_chk++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
      end
   endtask

   task automatic setup(input logic [1:0] f, input logic h, input logic c, input int n);
      rst_n = 1'b0;
      fmt_sel = f; hb3_on = h; cont_mode = c; cic_rate = 6'(n);
      tx_strobe = 1'b0; pin_data = '0;
      S  = (f == 2'b10) ? 1 : (f == 2'b01) ? 2 : 4;
      SW = 12 / S;
      P  = (4 * n) / S;
      if (!h) P = P / 2;
      repeat (3) @(negedge clk);
      got_n = 0; nw = 0; exp_n = 0; dbl = 0;
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic push(input logic lv, input logic [11:0] pins);
      m_lvl[nw] = lv; m_pin[nw] = pins; nw++;
      tx_strobe = lv; pin_data = pins;
      repeat (P) @(negedge clk);
   endtask

   function automatic logic [11:0] piece(input logic [11:0] v, input int k);
      logic [11:0] sl, junk;
      sl   = (v >> (12 - SW * (k + 1))) & 12'((1 << SW) - 1);
      junk = 12'($urandom) & 12'((1 << (12 - SW)) - 1);
      return (sl << (12 - SW)) | junk;
   endfunction

   task automatic push_pair(input logic [11:0] iv, input logic [11:0] qv, input logic qlow);
      for (int k = 0; k < S; k++) push(1'b1, piece(iv, k));
      for (int k = 0; k < S; k++) push(!qlow, piece(qv, k));
   endtask

   // word-level model built from the requirements
   task automatic model;
      logic        run, prevlow, rise;
      logic [11:0] acc, ih, d;
      int          idx;
      run = 0; prevlow = 1; acc = 0; ih = 0; idx = 0; exp_n = 0;
      for (int j = 0; j < nw; j++) begin
         rise = m_lvl[j] && (j == 0 || !m_lvl[j-1]);
         if (rise) begin run = 1; idx = 0; end
         if (run && cont_mode) begin
            if (m_lvl[j]) ih = m_pin[j];
            else if (exp_n < 256) begin
               exp_i[exp_n] = ih; exp_q[exp_n] = m_pin[j]; exp_n++;
            end
         end else if (run) begin
            d   = (!m_lvl[j] && prevlow) ? 12'd0 : (m_pin[j] >> (12 - SW));
            acc = 12'((acc << SW) | d);
            if (idx == S - 1) ih = acc;
            if (idx == 2 * S - 1) begin
               if (exp_n < 256) begin
                  exp_i[exp_n] = ih; exp_q[exp_n] = acc; exp_n++;
               end
               idx = 0;
            end else idx++;
         end
         prevlow = !m_lvl[j];
      end
   endtask

   task automatic finish_scn(input string tag);
      repeat (3 * P + 8) @(negedge clk);
      model();
      chk({tag, " pair count"}, (got_n >= exp_n) ? 1 : 0, 1);
      for (int e = 0; e < exp_n && e < got_n; e++) begin
         chk({tag, " I"}, int'(got_i[e]), int'(exp_i[e]));
         chk({tag, " Q"}, int'(got_q[e]), int'(exp_q[e]));
      end
      chk("R9 single-cycle valid", dbl, 0);
   endtask

   task automatic idle_tail(input int words);
      for (int k = 0; k < words; k++) push(1'b0, 12'($urandom));
   endtask

   initial begin : watchdog
      #(5.0 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      int t0;
      logic [1:0] f;
      logic h, c;
      void'($urandom(32'd20251));

      // R9 reset state
      repeat (3) @(negedge clk);
      chk("R9 reset valid", int'(out_valid), 0);
      chk("R9 reset I", int'(out_i), 0);
      chk("R9 reset Q", int'(out_q), 0);
      chk("R9 reset err", int'(cfg_err), 0);

      // R5 latency and period, full words, N=3, extra half-band on: P=12
      setup(2'b10, 1'b1, 1'b0, 3);
      t0 = cyc;
      push_pair(12'h5A3, 12'hA5C, 1'b0);
      push_pair(12'h801, 12'h7FF, 1'b0);
      idle_tail(3);
      chk("R5 first pair latency", (got_n > 0) ? got_c[0] - t0 : -1,
          3 + (2 * S - 1) * P + P / 2);
      finish_scn("R1");

      // R2 half words, minimum period (N=2, half-band off: P=2)
      setup(2'b01, 1'b0, 1'b0, 2);
      for (int k = 0; k < 4; k++) push_pair(12'($urandom), 12'($urandom), 1'b0);
      idle_tail(2 * S + 1);
      finish_scn("R2");

      // R3 quarter words
      setup(2'b00, 1'b1, 1'b0, 2);
      for (int k = 0; k < 3; k++) push_pair(12'($urandom), 12'($urandom), 1'b0);
      idle_tail(2 * S + 1);
      finish_scn("R3");

      // R4 resync mid-pair: half words, pair cut short by a low word
      setup(2'b01, 1'b1, 1'b0, 2);
      push(1'b1, piece(12'h3C5, 0));
      push(1'b1, piece(12'h3C5, 1));
      push(1'b1, piece(12'h9A6, 0));
      push(1'b0, 12'($urandom));
      push_pair(12'h147, 12'hEB8, 1'b0);
      idle_tail(2 * S + 1);
      finish_scn("R4");

      // R6 zero fill, alternate single-low Q words and long idle
      setup(2'b10, 1'b0, 1'b0, 3);
      push_pair(12'h111, 12'h222, 1'b1);
      push_pair(12'h333, 12'h444, 1'b1);
      idle_tail(6);
      push_pair(12'h555, 12'h666, 1'b0);
      idle_tail(4);
      finish_scn("R6");
      chk("R6 idle pair zero", (exp_n > 3) ? int'(exp_i[exp_n-1] | exp_q[exp_n-1]) : -1, 0);

      // R7 continuous: alternating, stuck high, stuck low
      setup(2'b10, 1'b0, 1'b1, 2);
      push(1'b1, 12'h0AB); push(1'b0, 12'h0CD);
      push(1'b1, 12'h123); push(1'b1, 12'h456); push(1'b0, 12'h789);
      push(1'b0, 12'hABC); push(1'b0, 12'hDEF);
      push(1'b1, 12'h321); push(1'b0, 12'h654);
      finish_scn("R7");

      // R8 illegal settings
      setup(2'b00, 1'b0, 1'b0, 4);
      chk("R8 quarter without half-band flag", int'(cfg_err), 1);
      push_pair(12'hFFF, 12'h001, 1'b0);
      repeat (3 * P) @(negedge clk);
      chk("R8 quarter without half-band no pair", got_n, 0);
      setup(2'b01, 1'b1, 1'b1, 4);
      chk("R8 continuous half flag", int'(cfg_err), 1);
      push(1'b1, 12'h100); push(1'b0, 12'h200);
      repeat (3 * P) @(negedge clk);
      chk("R8 continuous half no pair", got_n, 0);
      setup(2'b10, 1'b1, 1'b0, 1);
      chk("R8 rate below two flag", int'(cfg_err), 1);
      setup(2'b11, 1'b1, 1'b0, 3);
      chk("R8 reserved format flag", int'(cfg_err), 1);

      // constrained random mix
      for (int r = 0; r < 10; r++) begin
         c = (r % 3 == 0);
         if (c) f = 2'b10;
         else begin
            case ($urandom % 3)
               0: f = 2'b10;
               1: f = 2'b01;
               default: f = 2'b00;
            endcase
         end
         h = (f == 2'b00) ? 1'b1 : 1'($urandom);
         setup(f, h, c, 2 + int'($urandom % 4));
         if (c) begin
            for (int k = 0; k < 14; k++)
               push(($urandom % 4 == 0) ? (k % 2 == 1) : (k % 2 == 0), 12'($urandom));
            finish_scn("R7");
         end else begin
            for (int k = 0; k < 4 + int'($urandom % 3); k++) begin
               push_pair(12'($urandom), 12'($urandom), (f == 2'b10) && ($urandom % 3 == 0));
               if ($urandom % 3 == 0) idle_tail(1 + int'($urandom % 2));
            end
            idle_tail(2 * S + 1);
            finish_scn((f == 2'b10) ? "R1" : (f == 2'b01) ? "R2" : "R3");
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule